// File: doc/BRIEF.md
# Vector-Driven FIFO Word Bit Packer

This block sits between a 32-bit data FIFO and a one-bit-per-cycle serial protocol engine. On the transmit path it takes one 32-bit entry at a time and emits its bits serially. Up to four 10-bit field descriptors, held in two 32-bit configuration words, choose which bits are emitted and in what order. Each descriptor names a start bit, a walking direction and a field length, and may carry a stop flag. A descriptor may be used alone or chained to its neighbours to form a longer protocol word. A word-end strobe marks the serial bit that completes each protocol word of programmed size. The strobe count runs on across descriptors and across FIFO entries.

The receive path does the reverse with its own descriptor set. Serial bits are written into a cleared 32-bit accumulator at the positions the descriptors name. When the final descriptor of an entry is complete, the assembled word is offered on a valid/ready port. A descriptor whose field would leave bit range 0..31 raises a configuration error flag and is skipped by both paths. Software computes the descriptors. Protocol timing is left to the serial engine, which paces the bit port through its ready and valid signals.

Top module: `fifo_bit_packer`

## Requirements
- R1: Descriptor k (k = 0, 1) sits in bits [10k+9:10k] of the first configuration word, and descriptor k+2 in the same bits of the second. Within a descriptor, bits [9:5] are the start index, bit [4] is the direction (1 = descending indices), bits [3:1] are the length minus one, and bit [0] is the stop flag.
- R2: For each accepted transmit entry, the descriptors are used in order 0, 1, 2, 3. Each emits length+1 bits of the entry, beginning at its start index and walking down (direction 1) or up (direction 0).
- R3: The lowest-numbered descriptor with its stop flag set is the last one used for an entry. Descriptors after it have no effect, including on the error flag. If no stop flag is set, all four descriptors are used.
- R4: `ser_tx_last` is high with the serial bit that brings the running bit count to `tx_word_len_m1`+1, and the count then restarts. The count carries over descriptor and entry boundaries.
- R5: `tx_ready` is low from the cycle after an entry is accepted until the cycle after its final serial bit is taken, and is high otherwise.
- R6: While `ser_tx_valid` is high and `ser_tx_ready` is low, the presented bit and strobe stay unchanged.
- R7: Receive bits are written into the accumulator at the descriptor positions, in the same order as R2. After the last bit of the final descriptor, the word is presented on `rx_data` with `rx_valid` high.
- R8: Bit positions that no used receive descriptor covers read as zero in the presented word.
- R9: A presented receive word holds until `rx_ready` is high, and no serial bit is accepted (`ser_rx_ready` low) while it is held.
- R10: A used descriptor whose field would extend below bit 0 or above bit 31 sets that path's error flag (`tx_cfg_err` / `rx_cfg_err`), and its bits are neither sent nor received.
- R11: After reset, `tx_ready` is 1, `ser_tx_valid` is 0, `rx_valid` is 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_cfg_lo | input | 32 | Transmit descriptors 0 and 1 |
| tx_cfg_hi | input | 32 | Transmit descriptors 2 and 3 |
| rx_cfg_lo | input | 32 | Receive descriptors 0 and 1 |
| rx_cfg_hi | input | 32 | Receive descriptors 2 and 3 |
| tx_word_len_m1 | input | 5 | Protocol word size minus one, used for the strobe |
| tx_valid | input | 1 | Transmit FIFO entry valid |
| tx_data | input | 32 | Transmit FIFO entry |
| tx_ready | output | 1 | Packer can take an entry |
| ser_tx_valid | output | 1 | Serial transmit bit valid |
| ser_tx_bit | output | 1 | Serial transmit bit |
| ser_tx_last | output | 1 | Bit completes a protocol word |
| ser_tx_ready | input | 1 | Serial engine takes the bit |
| tx_cfg_err | output | 1 | A used transmit descriptor is out of range |
| ser_rx_valid | input | 1 | Serial receive bit valid |
| ser_rx_bit | input | 1 | Serial receive bit |
| ser_rx_ready | output | 1 | Packer takes the receive bit |
| rx_valid | output | 1 | Assembled receive word valid |
| rx_data | output | 32 | Assembled receive word |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_cfg_err | output | 1 | A used receive descriptor is out of range |

## Verification
The bench covers chained descriptors that build one protocol word, with both walking directions. A design that mixed up the direction bit, or stepped one bit too few or too many, would send the fields mirrored or shifted. A protocol word size that does not divide the 32-bit entry makes the strobe cross entry boundaries, so a counter that restarted per entry would strobe early. The bench also uses a descriptor after the stop flag that is out of range but must be ignored, and out-of-range descriptors before the stop. A design that did not skip them would emit wrapped bits, hang, or raise the error flag wrongly. Serial and word-side backpressure are applied. Uncovered receive positions are checked for stale data left over from the previous entry.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_VEC = 4;
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int LEN_W   = 3;
  localparam int VEC_W   = IDX_W + 1 + LEN_W + 1;
  localparam int VSEL_W  = $clog2(NUM_VEC);

  // Field order matches the configuration bit layout, MSB first.
  typedef struct packed {
    logic [IDX_W-1:0] start;
    logic             desc;
    logic [LEN_W-1:0] len_m1;
    logic             stop;
  } pvec_t;

  function automatic logic [IDX_W-1:0] bit_pos(pvec_t v, logic [LEN_W-1:0] off);
    if (v.desc) bit_pos = v.start - IDX_W'(off);
    else        bit_pos = v.start + IDX_W'(off);
  endfunction

  function automatic logic fits(pvec_t v);
    logic [IDX_W:0] hi;
    hi = {1'b0, v.start} + (IDX_W+1)'(v.len_m1);
    if (v.desc) fits = (v.start >= IDX_W'(v.len_m1));
    else        fits = (hi <= (IDX_W+1)'(WORD_W-1));
  endfunction
endpackage

// File: rtl/fbp_vec_table.sv
module fbp_vec_table
  import fbp_pkg::*;
(
  input  logic [WORD_W-1:0]          cfg_lo,
  input  logic [WORD_W-1:0]          cfg_hi,
  output pvec_t [NUM_VEC-1:0]        vecs,
  output logic  [NUM_VEC-1:0]        vec_ok,
  output logic                       cfg_err
);
  localparam int PER_REG = NUM_VEC / 2;
  localparam int USED_W  = PER_REG * VEC_W;

  logic [NUM_VEC-1:0] stop_v;
  logic [VSEL_W-1:0]  last_sel;
  logic               unused_rsvd;

  assign unused_rsvd = ^{cfg_lo[WORD_W-1:USED_W], cfg_hi[WORD_W-1:USED_W]};

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    if (g < PER_REG) begin : g_lo
      assign vecs[g] = pvec_t'(cfg_lo[g*VEC_W +: VEC_W]);
    end else begin : g_hi
      assign vecs[g] = pvec_t'(cfg_hi[(g-PER_REG)*VEC_W +: VEC_W]);
    end
    assign vec_ok[g] = fits(vecs[g]);
    assign stop_v[g] = vecs[g].stop;
  end

  // Lowest descriptor carrying a stop flag ends the entry.
  always_comb begin
    last_sel = VSEL_W'(NUM_VEC-1);
    for (int i = NUM_VEC-1; i >= 0; i--) begin
      if (stop_v[i]) last_sel = VSEL_W'(i);
    end
  end

  always_comb begin
    cfg_err = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if ((VSEL_W'(i) <= last_sel) && !vec_ok[i]) cfg_err = 1'b1;
    end
  end
endmodule

// File: rtl/fbp_tx.sv
module fbp_tx
  import fbp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pvec_t [NUM_VEC-1:0]  vecs,
  input  logic  [NUM_VEC-1:0]  vec_ok,
  input  logic  [IDX_W-1:0]    word_len_m1,
  input  logic                 in_valid,
  input  logic  [WORD_W-1:0]   in_data,
  output logic                 in_ready,
  output logic                 bit_valid,
  output logic                 bit_out,
  output logic                 bit_last,
  input  logic                 bit_ready
);
  logic              busy_q, busy_d;
  logic [WORD_W-1:0] word_q;
  logic [VSEL_W-1:0] sel_q, sel_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;

  pvec_t cur;
  logic  cur_ok, last_vec, field_end, accept, shift, skip, vec_done;

  assign cur       = vecs[sel_q];
  assign cur_ok    = vec_ok[sel_q];
  assign last_vec  = cur.stop || (sel_q == VSEL_W'(NUM_VEC-1));
  assign field_end = (off_q == cur.len_m1);
  assign accept    = in_valid && !busy_q;
  assign shift     = busy_q && cur_ok && bit_ready;
  assign skip      = busy_q && !cur_ok;
  assign vec_done  = skip || (shift && field_end);

  assign in_ready  = !busy_q;
  assign bit_valid = busy_q && cur_ok;
  assign bit_out   = word_q[bit_pos(cur, off_q)];
  assign bit_last  = bit_valid && (cnt_q == word_len_m1);

  always_comb begin
    busy_d = busy_q;
    sel_d  = sel_q;
    off_d  = off_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      sel_d  = '0;
      off_d  = '0;
    end else if (vec_done) begin
      off_d = '0;
      if (last_vec) busy_d = 1'b0;
      else          sel_d  = sel_q + 1'b1;
    end else if (shift) begin
      off_d = off_q + 1'b1;
    end
    if (shift) cnt_d = bit_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
      off_q  <= off_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= in_data;
  end

  a_r6_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out) && $stable(bit_last)));

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r4_strobe_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bit_last |-> bit_valid);
endmodule

// File: rtl/fbp_rx.sv
module fbp_rx
  import fbp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pvec_t [NUM_VEC-1:0]  vecs,
  input  logic  [NUM_VEC-1:0]  vec_ok,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  output logic                 bit_ready,
  output logic                 out_valid,
  output logic  [WORD_W-1:0]   out_data,
  input  logic                 out_ready
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [VSEL_W-1:0] sel_q, sel_d;
  logic [LEN_W-1:0]  off_q, off_d;

  pvec_t cur;
  logic  cur_ok, last_vec, field_end, take, skip, vec_done, pop;

  assign cur       = vecs[sel_q];
  assign cur_ok    = vec_ok[sel_q];
  assign last_vec  = cur.stop || (sel_q == VSEL_W'(NUM_VEC-1));
  assign field_end = (off_q == cur.len_m1);
  assign bit_ready = !full_q && cur_ok;
  assign take      = bit_valid && bit_ready;
  assign skip      = !full_q && !cur_ok;
  assign vec_done  = skip || (take && field_end);
  assign pop       = full_q && out_ready;

  assign out_valid = full_q;
  assign out_data  = acc_q;

  always_comb begin
    acc_d  = acc_q;
    full_d = full_q;
    sel_d  = sel_q;
    off_d  = off_q;
    if (pop) begin
      acc_d  = '0;
      full_d = 1'b0;
    end else if (take) begin
      acc_d[bit_pos(cur, off_q)] = bit_in;
    end
    if (vec_done) begin
      off_d = '0;
      if (last_vec) begin
        full_d = 1'b1;
        sel_d  = '0;
      end else begin
        sel_d = sel_q + 1'b1;
      end
    end else if (take) begin
      off_d = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      acc_q  <= '0;
      sel_q  <= '0;
      off_q  <= '0;
    end else begin
      full_q <= full_d;
      acc_q  <= acc_d;
      sel_q  <= sel_d;
      off_q  <= off_d;
    end
  end

  a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_no_bits_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bit_ready);

  a_r8_cleared_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && (out_data[WORD_W-1:1] == '0 || $past(take))));
endmodule

// File: rtl/fifo_bit_packer.sv
module fifo_bit_packer
  import fbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_cfg_lo,
  input  logic [WORD_W-1:0] tx_cfg_hi,
  input  logic [WORD_W-1:0] rx_cfg_lo,
  input  logic [WORD_W-1:0] rx_cfg_hi,
  input  logic [IDX_W-1:0]  tx_word_len_m1,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              ser_tx_valid,
  output logic              ser_tx_bit,
  output logic              ser_tx_last,
  input  logic              ser_tx_ready,
  output logic              tx_cfg_err,
  input  logic              ser_rx_valid,
  input  logic              ser_rx_bit,
  output logic              ser_rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              rx_cfg_err
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;

  // Reset asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  pvec_t [NUM_VEC-1:0] tx_vecs, rx_vecs;
  logic  [NUM_VEC-1:0] tx_ok, rx_ok;

  fbp_vec_table u_tx_tbl (
    .cfg_lo (tx_cfg_lo),
    .cfg_hi (tx_cfg_hi),
    .vecs   (tx_vecs),
    .vec_ok (tx_ok),
    .cfg_err(tx_cfg_err)
  );

  fbp_vec_table u_rx_tbl (
    .cfg_lo (rx_cfg_lo),
    .cfg_hi (rx_cfg_hi),
    .vecs   (rx_vecs),
    .vec_ok (rx_ok),
    .cfg_err(rx_cfg_err)
  );

  fbp_tx u_tx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .vecs       (tx_vecs),
    .vec_ok     (tx_ok),
    .word_len_m1(tx_word_len_m1),
    .in_valid   (tx_valid),
    .in_data    (tx_data),
    .in_ready   (tx_ready),
    .bit_valid  (ser_tx_valid),
    .bit_out    (ser_tx_bit),
    .bit_last   (ser_tx_last),
    .bit_ready  (ser_tx_ready)
  );

  fbp_rx u_rx (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .vecs     (rx_vecs),
    .vec_ok   (rx_ok),
    .bit_valid(ser_rx_valid),
    .bit_in   (ser_rx_bit),
    .bit_ready(ser_rx_ready),
    .out_valid(rx_valid),
    .out_data (rx_data),
    .out_ready(rx_ready)
  );
endmodule

// File: tb/fifo_bit_packer_test.sv
module fifo_bit_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tx_cfg_lo = '0, tx_cfg_hi = '0, rx_cfg_lo = '0, rx_cfg_hi = '0;
  logic [4:0]  tx_word_len_m1 = '0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, ser_tx_valid, ser_tx_bit, ser_tx_last, tx_cfg_err;
  logic        ser_tx_ready = 1'b0;
  logic        ser_rx_valid = 1'b0, ser_rx_bit = 1'b0;
  logic        ser_rx_ready, rx_valid, rx_cfg_err;
  logic [31:0] rx_data;
  logic        rx_ready = 1'b0;

  always #2 clk = ~clk;

  fifo_bit_packer uut (
    .clk(clk), .rst_n(rst_n),
    .tx_cfg_lo(tx_cfg_lo), .tx_cfg_hi(tx_cfg_hi),
    .rx_cfg_lo(rx_cfg_lo), .rx_cfg_hi(rx_cfg_hi),
    .tx_word_len_m1(tx_word_len_m1),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ser_tx_valid(ser_tx_valid), .ser_tx_bit(ser_tx_bit), .ser_tx_last(ser_tx_last),
    .ser_tx_ready(ser_tx_ready), .tx_cfg_err(tx_cfg_err),
    .ser_rx_valid(ser_rx_valid), .ser_rx_bit(ser_rx_bit), .ser_rx_ready(ser_rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_cfg_err(rx_cfg_err)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int mcnt = 0;
  bit finished = 1'b0;
  bit strict = 1'b1;
  string tx_tag = "R2";
  string rx_tag = "R7";
  logic [31:0] seed = 32'h1234_5678;

  bit          exp_bit_q[$];
  bit          exp_last_q[$];
  logic [31:0] txw_q[$];
  bit          rxb_q[$];
  logic [31:0] rxexp_q[$];
  bit          walk_bits[$];
  logic [31:0] walk_mask;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [9:0] mkv(input int st, input bit ds, input int lm1, input bit sp);
    logic [9:0] v;
    v = {st[4:0], ds, lm1[2:0], sp};
    return v;
  endfunction

  // Both directions share one descriptor set per scenario.
  task automatic set_cfg(input logic [9:0] v0, input logic [9:0] v1, input logic [9:0] v2,
                         input logic [9:0] v3, input int wlm1);
    tx_cfg_lo = {12'h000, v1, v0};
    tx_cfg_hi = {12'h000, v3, v2};
    rx_cfg_lo = tx_cfg_lo;
    rx_cfg_hi = tx_cfg_hi;
    tx_word_len_m1 = wlm1[4:0];
  endtask

  function automatic logic [9:0] vec_of(input int i);
    if (i < 2) return tx_cfg_lo[i*10 +: 10];
    return tx_cfg_hi[(i-2)*10 +: 10];
  endfunction

  task automatic walk(input logic [31:0] w, output bit bad);
    logic [9:0] v;
    int st, ln, p;
    bit ok;
    walk_bits.delete();
    walk_mask = '0;
    bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      v  = vec_of(i);
      st = int'(v[9:5]);
      ln = int'(v[3:1]) + 1;
      ok = v[4] ? (st - ln + 1 >= 0) : (st + ln - 1 <= 31);
      if (!ok) bad = 1'b1;
      if (ok) begin
        for (int k = 0; k < ln; k++) begin
          p = v[4] ? st - k : st + k;
          walk_bits.push_back(w[p]);
          walk_mask[p] = 1'b1;
        end
      end
      if (v[0]) break;
    end
  endtask

  function automatic logic [31:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_valid = 1'b0;
    ser_rx_valid = 1'b0;
    exp_bit_q.delete(); exp_last_q.delete(); txw_q.delete(); rxb_q.delete(); rxexp_q.delete();
    mcnt = 0;
    repeat (2) @(negedge clk);
    check(tx_ready == 1'b1, "R11", 32'(tx_ready), 32'd1);
    check(ser_tx_valid == 1'b0, "R11", 32'(ser_tx_valid), 32'd0);
    check(rx_valid == 1'b0, "R11", 32'(rx_valid), 32'd0);
    check(rx_data == 32'd0, "R11", rx_data, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input int n, input bit exp_err);
    logic [31:0] w;
    bit bad;
    walk(32'd0, bad);
    check(bad == exp_err, "R10", 32'(bad), 32'(exp_err));
    check(tx_cfg_err == exp_err, "R10", 32'(tx_cfg_err), 32'(exp_err));
    check(rx_cfg_err == exp_err, "R10", 32'(rx_cfg_err), 32'(exp_err));
    for (int i = 0; i < n; i++) begin
      txw_q.push_back(next_word());
      w = next_word();
      walk(w, bad);
      foreach (walk_bits[j]) rxb_q.push_back(walk_bits[j]);
      rxexp_q.push_back(w & walk_mask);
    end
  endtask

  task automatic cycles(input int n, input int bp);
    bit b, l, bad;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cyc++;
      tx_valid     = (txw_q.size() > 0);
      tx_data      = tx_valid ? txw_q[0] : 32'd0;
      ser_tx_ready = (bp == 0) || (cyc % bp != 0);
      ser_rx_valid = (rxb_q.size() > 0) && ((bp == 0) || (cyc % (bp + 1) != 1));
      ser_rx_bit   = ser_rx_valid ? rxb_q[0] : 1'b0;
      rx_ready     = (bp == 0) || (cyc % bp != 1);
      #1;
      // R5: ready low while bits of an accepted entry remain
      if (exp_bit_q.size() > 0) check(tx_ready == 1'b0, "R5", 32'(tx_ready), 32'd0);
      else if (strict && tx_valid) check(tx_ready == 1'b1, "R5", 32'(tx_ready), 32'd1);
      if (ser_tx_valid && ser_tx_ready) begin
        if (exp_bit_q.size() == 0) begin
          check(1'b0, tx_tag, 32'd1, 32'd0);
        end else begin
          b = exp_bit_q.pop_front();
          l = exp_last_q.pop_front();
          check(ser_tx_bit == b, tx_tag, 32'(ser_tx_bit), 32'(b));
          check(ser_tx_last == l, "R4", 32'(ser_tx_last), 32'(l));
        end
      end
      if (tx_valid && tx_ready) begin
        walk(txw_q.pop_front(), bad);
        foreach (walk_bits[j]) begin
          exp_bit_q.push_back(walk_bits[j]);
          exp_last_q.push_back(mcnt == int'(tx_word_len_m1));
          mcnt = (mcnt == int'(tx_word_len_m1)) ? 0 : mcnt + 1;
        end
      end
      if (ser_rx_valid && ser_rx_ready) void'(rxb_q.pop_front());
      if (rx_valid) check(ser_rx_ready == 1'b0, "R9", 32'(ser_rx_ready), 32'd0);
      if (rx_valid && rx_ready) begin
        if (rxexp_q.size() == 0) begin
          check(1'b0, rx_tag, rx_data, 32'd0);
        end else begin
          check(rx_data == rxexp_q[0], rx_tag, rx_data, rxexp_q[0]);
          void'(rxexp_q.pop_front());
        end
      end
    end
    check(exp_bit_q.size() == 0 && txw_q.size() == 0, tx_tag,
          32'(exp_bit_q.size() + txw_q.size()), 32'd0);
    check(rxexp_q.size() == 0, rx_tag, 32'(rxexp_q.size()), 32'd0);
  endtask

  initial begin
    do_reset();

    // 7-bit words, four per entry, descending: R1 layout, R8 uncovered bits 7/15/23/31
    tx_tag = "R1"; rx_tag = "R8"; strict = 1'b1;
    set_cfg(mkv(6,1,6,0), mkv(14,1,6,0), mkv(22,1,6,0), mkv(30,1,6,1), 6);
    do_reset();
    load(5, 1'b0);
    cycles(400, 0);

    // 15-bit words, two per entry, ascending, with backpressure: R6, R7, R9
    tx_tag = "R6"; rx_tag = "R7";
    set_cfg(mkv(0,0,7,0), mkv(8,0,6,0), mkv(16,0,7,0), mkv(24,0,6,1), 14);
    do_reset();
    load(5, 1'b0);
    cycles(600, 3);

    // 23-bit word, stop on descriptor 2, bad descriptor 3 ignored: R3
    tx_tag = "R3"; rx_tag = "R3";
    set_cfg(mkv(22,1,7,0), mkv(14,1,7,0), mkv(6,1,6,1), mkv(0,1,7,0), 22);
    do_reset();
    load(5, 1'b0);
    cycles(400, 0);

    // Out-of-range descriptors before the stop are skipped: R10
    tx_tag = "R10"; rx_tag = "R10"; strict = 1'b0;
    set_cfg(mkv(2,1,7,0), mkv(8,0,7,0), mkv(28,0,7,1), mkv(0,0,0,0), 7);
    do_reset();
    load(5, 1'b0 | 1'b1);
    cycles(400, 2);

    // No stop flag: all four used; 12-bit words straddle entries: R3, R4
    tx_tag = "R4"; rx_tag = "R3"; strict = 1'b1;
    set_cfg(mkv(0,0,7,0), mkv(8,0,7,0), mkv(16,0,7,0), mkv(24,0,7,0), 11);
    do_reset();
    load(6, 1'b0);
    cycles(600, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule